// File: doc/BRIEF.md
# Speculative Store Undo Log

This block keeps an ordered log of undo records for instructions that a core retires while an older store is still waiting to finish. Each record holds what is needed to put the machine back: the physical destination register, the rename mapping it replaced, the register's prior value, the sequence tag of the instruction and, for stores, the block address and the memory contents that were overwritten. A store that has not finished yet is itself logged and marked unfinished. When the oldest unfinished store finishes, every record older than the next unfinished store is dropped at once.

When the core finds that another agent touched speculatively used data, it asks for a rollback and names the sequence tag of the oldest instruction that used the offending block. The log then plays its records back newest-first on an undo stream, several per cycle, and stops after the named record. While the replay runs, an inhibit output tells the coherence logic to hold off. After the replay, the log accepts no new records until every remaining unfinished store has finished, so retirement stays in order and the instruction that caused the rollback can make progress.

Both the log depth and the unfinished-store tracker depth must be powers of two.

Top module: `spec_undo_log`

## Requirements
- R1: A retiring lane is logged when it is an unfinished store (store flag and unfinished flag both 1), or when an unfinished store is older than it, either already in the log or in a lower-numbered lane of the same bundle. Lane 0 is the oldest lane. Any other lane retires without a record.
- R2: An undo record carries the tag, store flag, unfinished flag, physical register, previous mapping, previous value, block address and old memory data exactly as they were given at retirement.
- R3: A pulse on the store-finished input removes the oldest unfinished store and all records younger than it, up to but not including the next unfinished store. If there is no further unfinished store, it removes all of them.
- R4: A rollback replays records from the newest to the oldest. It stops after the record whose tag equals the requested tag. If no record matches, every record is replayed. A rollback request against an empty log is ignored.
- R5: The undo stream presents up to RET_W records per cycle. The valid lanes are contiguous from lane 0, and lane j holds the j-th newest record not yet replayed. The whole group is consumed on a cycle with ready high, and it stays unchanged while ready is low.
- R6: The inhibit output goes high in the cycle after an accepted rollback request. It falls in the cycle after the final undo transfer. While it is high, store-finished pulses and further rollback requests are ignored.
- R7: After a rollback, while any unfinished store remains, stall is high for any bundle that would need a record. Normal operation resumes once the last unfinished store has finished.
- R8: Stall is high, and the whole bundle is refused, when the bundle needs more records than there are free log slots, when it holds more unfinished stores than the tracker has room for, or when a rollback is in progress and the bundle has any valid lane.
- R9: After reset the log is empty, and stall, inhibit and every undo valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| retValid | input | RET_W | Retiring lane valid, lane 0 oldest |
| retIsStore | input | RET_W | Lane is a store |
| retStorePend | input | RET_W | Store on the lane has not finished |
| retTag | input | RET_W*TAG_W | Sequence tag per lane |
| retPreg | input | RET_W*PREG_W | Physical destination register per lane |
| retOldMap | input | RET_W*PREG_W | Rename mapping before the instruction |
| retOldVal | input | RET_W*DATA_W | Destination value before the instruction |
| retMemAddr | input | RET_W*ADDR_W | Block address written by a store |
| retMemOld | input | RET_W*DATA_W | Memory data overwritten by a store |
| retStall | output | 1 | Bundle refused this cycle |
| stDone | input | 1 | Oldest unfinished store has finished |
| rbReq | input | 1 | Rollback request pulse |
| rbTag | input | TAG_W | Tag of the oldest record to undo |
| coherInhibit | output | 1 | Rollback replay in progress |
| undoReady | input | 1 | Consumer accepts the undo group |
| undoValid | output | RET_W | Undo lane valid, lane 0 newest |
| undoTag | output | RET_W*TAG_W | Tag of the undo record |
| undoIsStore | output | RET_W | Record belongs to a store |
| undoPending | output | RET_W | Store was still unfinished |
| undoPreg | output | RET_W*PREG_W | Physical register to restore |
| undoOldMap | output | RET_W*PREG_W | Mapping to restore |
| undoOldVal | output | RET_W*DATA_W | Register value to restore |
| undoMemAddr | output | RET_W*ADDR_W | Block address to restore |
| undoMemOld | output | RET_W*DATA_W | Memory data to restore |

## Verification
The bench builds the log with a depth of 8 and a store tracker of 4, keeping the four-wide retire and undo lanes. With these sizes, two bundles fill the log and one bundle fills the tracker, so both stall causes are easy to reach, and repeated fill-and-replay runs make the pointers wrap several times. Each replay of eight records takes two undo cycles, so a rollback that ends inside the second group, and a replay held off by a low ready, can both be observed.

// File: rtl/spec_undo_log_pkg.sv
package spec_undo_log_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_UNDO = 2'd1,
    ST_HOLD = 2'd2
  } qstate_e;

  typedef struct packed {
    logic accept;
    logic rolling;
  } strobe_t;

endpackage

// File: rtl/spec_undo_log_ctrl.sv
module spec_undo_log_ctrl
  import spec_undo_log_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int RET_W     = 4,
  parameter int TAG_W     = 10,
  parameter int STQ_DEPTH = 16
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [RET_W-1:0]                          retValid,
  input  logic [RET_W-1:0]                          retIsStore,
  input  logic [RET_W-1:0]                          retStorePend,
  input  logic                                      stDone,
  input  logic                                      rbReq,
  input  logic [TAG_W-1:0]                          rbTag,
  input  logic                                      undoReady,
  input  logic [RET_W-1:0][TAG_W-1:0]               rdTag,
  input  logic [RET_W-1:0]                          rdPend,
  output strobe_t                                   strb,
  output logic [RET_W-1:0]                          laneNeed,
  output logic [RET_W-1:0][$clog2(DEPTH)-1:0]       laneSlot,
  output logic [RET_W-1:0][$clog2(DEPTH)-1:0]       rdSlot,
  output logic [RET_W-1:0]                          undoValid,
  output logic                                      retStall,
  output logic                                      coherInhibit
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int SQ_W  = $clog2(STQ_DEPTH);
  localparam int SC_W  = SQ_W + 1;

  qstate_e                       state;
  logic [PTR_W-1:0]              headPtr, tailPtr, count, headNx, firstPushPtr;
  logic [PTR_W-1:0]              sqMem [STQ_DEPTH];
  logic [SQ_W-1:0]               sqRd, sqWr;
  logic [SC_W-1:0]               sqCnt;
  logic [TAG_W-1:0]              tgtTag;
  logic [RET_W-1:0]              pendStore;
  logic [RET_W-1:0][PTR_W-1:0]   lanePtr, rdPtr;
  logic [RET_W-1:0][SQ_W-1:0]    sqPushIdx;
  int                            needCnt, pushCnt, emitCnt, popStores, sqNext;
  logic                          olderPend, hit, fire, finish, doDone, rbStart, accept;

  assign count = tailPtr - headPtr;

  // retire lane decode: which lanes log, and where they land
  always_comb begin
    olderPend    = (sqCnt != '0);
    needCnt      = 0;
    pushCnt      = 0;
    firstPushPtr = tailPtr;
    for (int i = 0; i < RET_W; i++) begin
      pendStore[i] = retValid[i] & retIsStore[i] & retStorePend[i];
      laneNeed[i]  = retValid[i] & (pendStore[i] | olderPend);
      lanePtr[i]   = tailPtr + PTR_W'(needCnt);
      sqPushIdx[i] = sqWr + SQ_W'(pushCnt);
      if (pendStore[i] && pushCnt == 0) firstPushPtr = lanePtr[i];
      if (laneNeed[i]) needCnt = needCnt + 1;
      if (pendStore[i]) pushCnt = pushCnt + 1;
      olderPend   = olderPend | pendStore[i];
      laneSlot[i] = lanePtr[i][IDX_W-1:0];
    end
  end

  always_comb begin
    case (state)
      ST_UNDO: retStall = |retValid;
      ST_HOLD: retStall = |laneNeed;
      default: retStall = (needCnt > DEPTH - int'(count)) ||
                          (pushCnt > STQ_DEPTH - int'(sqCnt));
    endcase
    accept = !retStall && (needCnt != 0);
  end

  // undo lane selection, newest first, stopping at the target tag
  always_comb begin
    hit       = 1'b0;
    emitCnt   = 0;
    popStores = 0;
    for (int j = 0; j < RET_W; j++) begin
      rdPtr[j]     = tailPtr - PTR_W'(j + 1);
      rdSlot[j]    = rdPtr[j][IDX_W-1:0];
      undoValid[j] = (state == ST_UNDO) && (j < int'(count)) && !hit;
      if (undoValid[j]) begin
        emitCnt = emitCnt + 1;
        if (rdPend[j]) popStores = popStores + 1;
        if (rdTag[j] == tgtTag) hit = 1'b1;
      end
    end
    fire   = (state == ST_UNDO) && undoReady;
    finish = fire && (hit || emitCnt == int'(count));
  end

  assign doDone  = stDone && (state != ST_UNDO) && (sqCnt != '0);
  assign rbStart = rbReq && (state != ST_UNDO) && (count != '0);

  always_comb begin
    if (int'(sqCnt) >= 2)             headNx = sqMem[sqRd + SQ_W'(1)];
    else if (accept && pushCnt > 0)   headNx = firstPushPtr;
    else if (accept)                  headNx = tailPtr + PTR_W'(needCnt);
    else                              headNx = tailPtr;
    sqNext = int'(sqCnt) + (accept ? pushCnt : 0) - (doDone ? 1 : 0) - (fire ? popStores : 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      headPtr <= '0;
      tailPtr <= '0;
      sqRd    <= '0;
      sqWr    <= '0;
      sqCnt   <= '0;
      tgtTag  <= '0;
    end else begin
      if (doDone) begin
        headPtr <= headNx;
        sqRd    <= sqRd + SQ_W'(1);
      end
      if (accept) begin
        tailPtr <= tailPtr + PTR_W'(needCnt);
        sqWr    <= sqWr + SQ_W'(pushCnt);
      end else if (fire) begin
        tailPtr <= tailPtr - PTR_W'(emitCnt);
        sqWr    <= sqWr - SQ_W'(popStores);
      end
      sqCnt <= SC_W'(sqNext);
      case (state)
        ST_UNDO: if (finish) state <= (sqNext == 0) ? ST_RUN : ST_HOLD;
        default: begin
          if (rbStart) begin
            state  <= ST_UNDO;
            tgtTag <= rbTag;
          end else if (state == ST_HOLD && sqNext == 0) begin
            state <= ST_RUN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < RET_W; i++)
      if (accept && pendStore[i]) sqMem[sqPushIdx[i]] <= lanePtr[i];
  end

  assign coherInhibit = (state == ST_UNDO);
  assign strb.accept  = accept;
  assign strb.rolling = (state == ST_UNDO);

  p_count_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH);
  p_sq_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(sqCnt) <= STQ_DEPTH);
  p_undo_contig_r5: assert property (@(posedge clk) disable iff (!rstN)
    (undoValid & (undoValid + RET_W'(1))) == '0);
  p_rb_inhibit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rbReq && !coherInhibit && count != '0) |=> coherInhibit);
  p_head_still_r6: assert property (@(posedge clk) disable iff (!rstN)
    coherInhibit |=> $stable(headPtr));
  p_empty_no_undo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (undoValid == '0));
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && |laneNeed) |-> retStall);

endmodule

// File: rtl/spec_undo_log_dp.sv
module spec_undo_log_dp
  import spec_undo_log_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int RET_W  = 4,
  parameter int TAG_W  = 10,
  parameter int PREG_W = 7,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                                clk,
  input  strobe_t                             strb,
  input  logic [RET_W-1:0]                    laneNeed,
  input  logic [RET_W-1:0][$clog2(DEPTH)-1:0] laneSlot,
  input  logic [RET_W-1:0][$clog2(DEPTH)-1:0] rdSlot,
  input  logic [RET_W-1:0]                    retIsStore,
  input  logic [RET_W-1:0]                    retStorePend,
  input  logic [RET_W-1:0][TAG_W-1:0]         retTag,
  input  logic [RET_W-1:0][PREG_W-1:0]        retPreg,
  input  logic [RET_W-1:0][PREG_W-1:0]        retOldMap,
  input  logic [RET_W-1:0][DATA_W-1:0]        retOldVal,
  input  logic [RET_W-1:0][ADDR_W-1:0]        retMemAddr,
  input  logic [RET_W-1:0][DATA_W-1:0]        retMemOld,
  output logic [RET_W-1:0][TAG_W-1:0]         rdTag,
  output logic [RET_W-1:0]                    rdPend,
  output logic [RET_W-1:0][TAG_W-1:0]         undoTag,
  output logic [RET_W-1:0]                    undoIsStore,
  output logic [RET_W-1:0]                    undoPending,
  output logic [RET_W-1:0][PREG_W-1:0]        undoPreg,
  output logic [RET_W-1:0][PREG_W-1:0]        undoOldMap,
  output logic [RET_W-1:0][DATA_W-1:0]        undoOldVal,
  output logic [RET_W-1:0][ADDR_W-1:0]        undoMemAddr,
  output logic [RET_W-1:0][DATA_W-1:0]        undoMemOld
);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              isStore;
    logic              pend;
    logic [PREG_W-1:0] preg;
    logic [PREG_W-1:0] oldMap;
    logic [DATA_W-1:0] oldVal;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] memOld;
  } rec_t;

  rec_t mem [DEPTH];
  rec_t wrRec [RET_W];
  rec_t rdRec [RET_W];

  always_comb begin
    for (int i = 0; i < RET_W; i++) begin
      wrRec[i].tag     = retTag[i];
      wrRec[i].isStore = retIsStore[i];
      wrRec[i].pend    = retIsStore[i] & retStorePend[i];
      wrRec[i].preg    = retPreg[i];
      wrRec[i].oldMap  = retOldMap[i];
      wrRec[i].oldVal  = retOldVal[i];
      wrRec[i].addr    = retMemAddr[i];
      wrRec[i].memOld  = retMemOld[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < RET_W; i++)
      if (strb.accept && laneNeed[i]) mem[laneSlot[i]] <= wrRec[i];
  end

  always_comb begin
    for (int j = 0; j < RET_W; j++) begin
      rdRec[j]       = mem[rdSlot[j]];
      rdTag[j]       = rdRec[j].tag;
      rdPend[j]      = rdRec[j].pend;
      undoTag[j]     = strb.rolling ? rdRec[j].tag     : '0;
      undoIsStore[j] = strb.rolling ? rdRec[j].isStore : 1'b0;
      undoPending[j] = strb.rolling ? rdRec[j].pend    : 1'b0;
      undoPreg[j]    = strb.rolling ? rdRec[j].preg    : '0;
      undoOldMap[j]  = strb.rolling ? rdRec[j].oldMap  : '0;
      undoOldVal[j]  = strb.rolling ? rdRec[j].oldVal  : '0;
      undoMemAddr[j] = strb.rolling ? rdRec[j].addr    : '0;
      undoMemOld[j]  = strb.rolling ? rdRec[j].memOld  : '0;
    end
  end

endmodule

// File: rtl/spec_undo_log.sv
module spec_undo_log
  import spec_undo_log_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int RET_W     = 4,
  parameter int TAG_W     = 10,
  parameter int PREG_W    = 7,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 32,
  parameter int STQ_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [RET_W-1:0]             retValid,
  input  logic [RET_W-1:0]             retIsStore,
  input  logic [RET_W-1:0]             retStorePend,
  input  logic [RET_W-1:0][TAG_W-1:0]  retTag,
  input  logic [RET_W-1:0][PREG_W-1:0] retPreg,
  input  logic [RET_W-1:0][PREG_W-1:0] retOldMap,
  input  logic [RET_W-1:0][DATA_W-1:0] retOldVal,
  input  logic [RET_W-1:0][ADDR_W-1:0] retMemAddr,
  input  logic [RET_W-1:0][DATA_W-1:0] retMemOld,
  output logic                         retStall,
  input  logic                         stDone,
  input  logic                         rbReq,
  input  logic [TAG_W-1:0]             rbTag,
  output logic                         coherInhibit,
  input  logic                         undoReady,
  output logic [RET_W-1:0]             undoValid,
  output logic [RET_W-1:0][TAG_W-1:0]  undoTag,
  output logic [RET_W-1:0]             undoIsStore,
  output logic [RET_W-1:0]             undoPending,
  output logic [RET_W-1:0][PREG_W-1:0] undoPreg,
  output logic [RET_W-1:0][PREG_W-1:0] undoOldMap,
  output logic [RET_W-1:0][DATA_W-1:0] undoOldVal,
  output logic [RET_W-1:0][ADDR_W-1:0] undoMemAddr,
  output logic [RET_W-1:0][DATA_W-1:0] undoMemOld
);

  localparam int IDX_W = $clog2(DEPTH);

  strobe_t                       strb;
  logic [RET_W-1:0]              laneNeed, rdPend;
  logic [RET_W-1:0][IDX_W-1:0]   laneSlot, rdSlot;
  logic [RET_W-1:0][TAG_W-1:0]   rdTag;

  spec_undo_log_ctrl #(
    .DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W), .STQ_DEPTH(STQ_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .retValid(retValid), .retIsStore(retIsStore), .retStorePend(retStorePend),
    .stDone(stDone), .rbReq(rbReq), .rbTag(rbTag), .undoReady(undoReady),
    .rdTag(rdTag), .rdPend(rdPend),
    .strb(strb), .laneNeed(laneNeed), .laneSlot(laneSlot), .rdSlot(rdSlot),
    .undoValid(undoValid), .retStall(retStall), .coherInhibit(coherInhibit)
  );

  spec_undo_log_dp #(
    .DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W), .PREG_W(PREG_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .strb(strb), .laneNeed(laneNeed), .laneSlot(laneSlot), .rdSlot(rdSlot),
    .retIsStore(retIsStore), .retStorePend(retStorePend), .retTag(retTag),
    .retPreg(retPreg), .retOldMap(retOldMap), .retOldVal(retOldVal),
    .retMemAddr(retMemAddr), .retMemOld(retMemOld),
    .rdTag(rdTag), .rdPend(rdPend),
    .undoTag(undoTag), .undoIsStore(undoIsStore), .undoPending(undoPending),
    .undoPreg(undoPreg), .undoOldMap(undoOldMap), .undoOldVal(undoOldVal),
    .undoMemAddr(undoMemAddr), .undoMemOld(undoMemOld)
  );

endmodule

// File: tb/spec_undo_log_test.sv
module spec_undo_log_test;

  localparam int DEPTH = 8, RET_W = 4, TAG_W = 8, PREG_W = 6;
  localparam int DATA_W = 16, ADDR_W = 12, STQ_DEPTH = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [RET_W-1:0] retValid = '0, retIsStore = '0, retStorePend = '0;
  logic [RET_W-1:0][TAG_W-1:0]  retTag = '0;
  logic [RET_W-1:0][PREG_W-1:0] retPreg = '0, retOldMap = '0;
  logic [RET_W-1:0][DATA_W-1:0] retOldVal = '0, retMemOld = '0;
  logic [RET_W-1:0][ADDR_W-1:0] retMemAddr = '0;
  logic retStall, stDone = 1'b0, rbReq = 1'b0, coherInhibit, undoReady = 1'b0;
  logic [TAG_W-1:0] rbTag = '0;
  logic [RET_W-1:0] undoValid, undoIsStore, undoPending;
  logic [RET_W-1:0][TAG_W-1:0]  undoTag;
  logic [RET_W-1:0][PREG_W-1:0] undoPreg, undoOldMap;
  logic [RET_W-1:0][DATA_W-1:0] undoOldVal, undoMemOld;
  logic [RET_W-1:0][ADDR_W-1:0] undoMemAddr;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spec_undo_log #(
    .DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W), .PREG_W(PREG_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STQ_DEPTH(STQ_DEPTH)
  ) uut (.*);

  function automatic logic [PREG_W-1:0] fPreg(input logic [7:0] t);   return t[5:0] ^ 6'h15; endfunction
  function automatic logic [PREG_W-1:0] fMap(input logic [7:0] t);    return t[5:0] + 6'd3; endfunction
  function automatic logic [DATA_W-1:0] fVal(input logic [7:0] t);    return {t, ~t}; endfunction
  function automatic logic [ADDR_W-1:0] fAddr(input logic [7:0] t);   return {4'h9, t}; endfunction
  function automatic logic [DATA_W-1:0] fMem(input logic [7:0] t);    return {~t, t}; endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doRetire(input logic [3:0] v, input logic [3:0] st, input logic [3:0] p,
                          input int base, output bit stallSeen);
    @(negedge clk);
    for (int i = 0; i < RET_W; i++) begin
      retValid[i]     = v[i];
      retIsStore[i]   = st[i];
      retStorePend[i] = p[i];
      retTag[i]       = 8'(base + i);
      retPreg[i]      = fPreg(8'(base + i));
      retOldMap[i]    = fMap(8'(base + i));
      retOldVal[i]    = fVal(8'(base + i));
      retMemAddr[i]   = fAddr(8'(base + i));
      retMemOld[i]    = fMem(8'(base + i));
    end
    #1 stallSeen = retStall;
    @(posedge clk);
    #1 retValid = '0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    stDone = 1'b1;
    @(posedge clk);
    #1 stDone = 1'b0;
  endtask

  task automatic rollAll(input logic [7:0] tgt, output int n, output int firstTag,
                         output int lastTag, output bit inhSeen);
    n = 0; firstTag = -1; lastTag = -1; inhSeen = 1'b0;
    @(negedge clk);
    rbReq = 1'b1; rbTag = tgt; undoReady = 1'b1;
    @(posedge clk);
    #1 rbReq = 1'b0;
    @(negedge clk);
    for (int g = 0; g < 40 && coherInhibit; g++) begin
      inhSeen = 1'b1;
      for (int j = 0; j < RET_W; j++)
        if (undoValid[j]) begin
          if (n == 0) firstTag = int'(undoTag[j]);
          lastTag = int'(undoTag[j]);
          n++;
        end
      @(negedge clk);
    end
  endtask

  // valid[11:8], unfinished stores[7:4], expected record count[3:0]
  localparam logic [11:0] ROWS [7] = '{
    12'b1111_0000_0000, 12'b1111_0001_0100, 12'b1111_0100_0010,
    12'b1010_1000_0001, 12'b1111_1000_0001, 12'b0111_0010_0010,
    12'b1111_1010_0011 };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit st;
    int n, ft, lt;
    bit inh;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R9", "stall after reset", int'(retStall), 0);
    chk("R9", "inhibit after reset", int'(coherInhibit), 0);
    chk("R9", "undo valid after reset", int'(undoValid), 0);

    // R1/R4: table of bundles, each replayed completely with an unmatched tag
    for (int r = 0; r < 7; r++) begin
      int base, newest;
      base = 60 + r * 8;
      newest = 0;
      for (int i = 0; i < RET_W; i++) if (ROWS[r][8+i]) newest = i;
      doRetire(ROWS[r][11:8], ROWS[r][7:4], ROWS[r][7:4], base, st);
      chk("R1", "table bundle stall", int'(st), 0);
      rollAll(8'hFF, n, ft, lt, inh);
      chk("R1", "records logged", n, int'(ROWS[r][3:0]));
      if (ROWS[r][3:0] != 0) chk("R4", "newest replayed first", ft, base + newest);
      else chk("R4", "empty rollback ignored", int'(inh), 0);
    end

    // R8: full log refuses the bundle
    doRetire(4'b1111, 4'b0001, 4'b0001, 10, st);
    chk("R8", "first bundle", int'(st), 0);
    doRetire(4'b1111, 4'b0000, 4'b0000, 14, st);
    chk("R1", "younger bundle logged", int'(st), 0);
    doRetire(4'b0001, 4'b0000, 4'b0000, 18, st);
    chk("R8", "stall when full", int'(st), 1);

    // R4/R5/R6: rollback to tag 12 with ready held low at first
    @(negedge clk);
    rbReq = 1'b1; rbTag = 8'd12; undoReady = 1'b0;
    @(posedge clk);
    #1 rbReq = 1'b0;
    @(negedge clk);
    chk("R6", "inhibit after request", int'(coherInhibit), 1);
    chk("R5", "first group valid", int'(undoValid), 15);
    chk("R5", "lane0 newest tag", int'(undoTag[0]), 17);
    chk("R8", "stall during rollback", int'(retStall), 0);
    stDone = 1'b1;
    @(posedge clk);
    #1 stDone = 1'b0;
    @(negedge clk);
    chk("R5", "group held while not ready", int'(undoValid), 15);
    chk("R5", "tag held while not ready", int'(undoTag[0]), 17);
    chk("R5", "lane3 tag", int'(undoTag[3]), 14);
    undoReady = 1'b1;
    @(negedge clk);
    chk("R4", "stops at target", int'(undoValid), 3);
    chk("R5", "second group lane0", int'(undoTag[0]), 13);
    chk("R4", "target lane tag", int'(undoTag[1]), 12);
    chk("R2", "preg", int'(undoPreg[1]), int'(fPreg(8'd12)));
    chk("R2", "old map", int'(undoOldMap[1]), int'(fMap(8'd12)));
    chk("R2", "old value", int'(undoOldVal[1]), int'(fVal(8'd12)));
    chk("R2", "block address", int'(undoMemAddr[1]), int'(fAddr(8'd12)));
    chk("R2", "old memory", int'(undoMemOld[1]), int'(fMem(8'd12)));
    chk("R2", "store flag", int'(undoIsStore[1]), 0);
    @(negedge clk);
    chk("R6", "inhibit falls after last transfer", int'(coherInhibit), 0);
    chk("R6", "no undo after finish", int'(undoValid), 0);

    // R7 (and R6: completion during replay was ignored, store 10 still unfinished)
    doRetire(4'b0001, 4'b0000, 4'b0000, 30, st);
    chk("R7", "stall while store unfinished", int'(st), 1);
    pulseDone();
    doRetire(4'b0001, 4'b0000, 4'b0000, 31, st);
    chk("R7", "resumes after completion", int'(st), 0);
    rollAll(8'hFF, n, ft, lt, inh);
    chk("R3", "completion emptied log", n, 0);

    // R3: drain up to the next unfinished store
    doRetire(4'b1111, 4'b0101, 4'b0101, 20, st);
    pulseDone();
    rollAll(8'hFF, n, ft, lt, inh);
    chk("R3", "records left", n, 2);
    chk("R3", "newest left", ft, 23);
    chk("R3", "oldest left", lt, 22);

    // R8: store tracker full
    doRetire(4'b1111, 4'b1111, 4'b1111, 50, st);
    chk("R8", "four unfinished stores", int'(st), 0);
    doRetire(4'b0001, 4'b0001, 4'b0001, 54, st);
    chk("R8", "stall when tracker full", int'(st), 1);
    doRetire(4'b0001, 4'b0000, 4'b0000, 55, st);
    chk("R8", "non-store still fits", int'(st), 0);
    rollAll(8'hFF, n, ft, lt, inh);
    chk("R8", "refused store not logged", n, 5);
    chk("R4", "newest after refusal", ft, 55);
    chk("R4", "oldest replayed", lt, 50);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule